// File: doc/BRIEF.md
# Class B Trap Controller

This block sits beside the decode and execute stages of a 16-bit processor. It watches five fault conditions: an invalid opcode, a protected instruction run with its protection broken, a word operand access to an odd byte address, a branch to an odd byte address, and an external access made while no external bus configuration exists. Each fault sets its own bit in a trap flag register. The flag register stays set until software clears it by writing ones. The block also picks the instruction address that the trap entry sequence pushes onto the stack, and it raises a one-cycle trap request that carries a single shared vector.

The stacked address depends on the kind of fault. An opcode or protection fault stacks the address of the faulting instruction. An odd branch stacks the bad target itself. An odd operand access or a bad bus access stacks the address of the next instruction. When several faults arrive in one cycle, a fixed priority picks the address, and every matching flag is still set.

While a Class A trap routine runs, new faults only set their flags and their addresses are discarded. The trap request for them comes on the cycle after the return-from-interrupt strobe that ends the Class A routine, and it stacks that strobe's return address. After a request, no other request is made until the entry sequence acknowledges the current one.

Top module: `trapb_ctrl`

## Requirements
- R1: Flag bits are: bit 0 undefined opcode (`insn_valid` and `insn_undef`), bit 1 protection fault (`prot_viol`), bit 2 odd branch target (`branch_take` and `branch_target[0]`), bit 3 odd word operand (`data_req`, `data_word` and `data_addr_lsb`), bit 4 bad bus access (`ext_req` and not `bus_cfg`). Each condition sets its bit on the clock edge that ends the cycle in which it is present.
- R2: For an undefined opcode or a protection fault, `trap_ip` is `cur_ip`.
- R3: For an odd branch target, `trap_ip` is `branch_target`. For an odd word operand or a bad bus access, `trap_ip` is `next_ip`.
- R4: When several faults occur in one cycle, `trap_ip` follows the priority bit 0 > bit 1 > bit 2 > bit 3 > bit 4, and every matching flag is set.
- R5: A cycle with `flag_wr` high clears exactly the flag bits at which `flag_wdata` holds 1. All other bits keep their value.
- R6: A hardware set and a software clear of the same bit in the same cycle leave the bit set.
- R7: `trap_req` is a one-cycle pulse, high in the cycle after the fault. `trap_vec` equals `TRAP_VEC` while `trap_req` is high and 0 otherwise.
- R8: After a request, no new request is issued until `trap_ack`. Faults in that time set their flags but are never requested.
- R9: A fault while `class_a_act` is high sets its flag and raises no request. In the cycle after the next `reti`, `trap_req` rises with `trap_ip` equal to `reti_ip`.
- R10: A byte access, an even address, a branch that is not taken, an external access with `bus_cfg` high, and `insn_undef` without `insn_valid` set no flag and raise no request.
- R11: After reset, `flags` is 0, `trap_req` is 0 and `trap_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Decode stage holds an instruction this cycle |
| insn_undef | input | 1 | Decoded opcode is invalid |
| prot_viol | input | 1 | Protected instruction ran with its protection broken |
| data_req | input | 1 | Data operand access this cycle |
| data_word | input | 1 | Data access is word sized |
| data_addr_lsb | input | 1 | Bit 0 of the data access address |
| branch_take | input | 1 | Branch taken this cycle |
| branch_target | input | ADDR_W | Branch target address |
| ext_req | input | 1 | External fetch, read or write requested |
| bus_cfg | input | 1 | An external bus configuration exists |
| cur_ip | input | ADDR_W | Address of the current instruction |
| next_ip | input | ADDR_W | Address of the following instruction |
| reti | input | 1 | Return from interrupt executes |
| reti_ip | input | ADDR_W | Return address of that return |
| class_a_act | input | 1 | A Class A trap routine is running |
| flag_wr | input | 1 | Software write to the flag register |
| flag_wdata | input | 5 | Write-one-to-clear data |
| trap_ack | input | 1 | Trap entry sequence accepted the request |
| flags | output | 5 | Trap flag register |
| trap_req | output | 1 | Trap entry request pulse |
| trap_vec | output | VEC_W | Vector index, valid with trap_req |
| trap_ip | output | ADDR_W | Address to stack, valid with trap_req |

## Verification
All 32 combinations of the five fault inputs are swept with Class A idle. Each run uses its own distinct current, next and target addresses, so a wrong priority or a swapped address source shows up as a wrong `trap_ip`, and a missing or extra flag shows up in `flags`. Separate patterns present the near-miss conditions (byte access, even address, no decode, configured bus) to tell a real fault from a lookalike. Other patterns hold back acknowledge to show that later faults are dropped, and raise Class A to show that the deferred request comes with the return address rather than the faulting one. The write-one-to-clear patterns use a partial mask and a clear that collides with a set.

// File: rtl/trapb_pkg.sv
package trapb_pkg;
    localparam int NFLAG     = 5;
    localparam int FB_UNDEF  = 0;
    localparam int FB_PROT   = 1;
    localparam int FB_ODDBR  = 2;
    localparam int FB_ODDOP  = 3;
    localparam int FB_NOBUS  = 4;

    typedef logic [NFLAG-1:0] flag_t;

    typedef enum logic [1:0] {
        IPSRC_CUR  = 2'd0,
        IPSRC_NEXT = 2'd1,
        IPSRC_BR   = 2'd2
    } ipsrc_e;

    function automatic ipsrc_e ip_source(input int idx);
        case (idx)
            FB_UNDEF, FB_PROT: return IPSRC_CUR;
            FB_ODDBR:          return IPSRC_BR;
            default:           return IPSRC_NEXT;
        endcase
    endfunction
endpackage

// File: rtl/trapb_detect.sv
module trapb_detect
    import trapb_pkg::*;
(
    input  logic  insn_valid,
    input  logic  insn_undef,
    input  logic  prot_viol,
    input  logic  data_req,
    input  logic  data_word,
    input  logic  data_addr_lsb,
    input  logic  branch_take,
    input  logic  branch_lsb,
    input  logic  ext_req,
    input  logic  bus_cfg,
    output flag_t fault
);
    always_comb begin
        fault           = '0;
        fault[FB_UNDEF] = insn_valid & insn_undef;
        fault[FB_PROT]  = prot_viol;
        fault[FB_ODDBR] = branch_take & branch_lsb;
        fault[FB_ODDOP] = data_req & data_word & data_addr_lsb;
        fault[FB_NOBUS] = ext_req & ~bus_cfg;
    end
endmodule

// File: rtl/trapb_flags.sv
module trapb_flags
    import trapb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  flag_t hw_set,
    input  logic  sw_wr,
    input  flag_t sw_wdata,
    output flag_t flags
);
    flag_t flags_d, flags_q;
    flag_t clr_mask;

    always_comb begin
        clr_mask = sw_wr ? sw_wdata : '0;
        // a set in the same cycle overrides the clear
        flags_d  = (flags_q & ~clr_mask) | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/trapb_issue.sv
module trapb_issue
    import trapb_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              VEC_W    = 4,
    parameter logic [VEC_W-1:0] TRAP_VEC = 4'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  flag_t             fault,
    input  logic [ADDR_W-1:0] cur_ip,
    input  logic [ADDR_W-1:0] next_ip,
    input  logic [ADDR_W-1:0] branch_target,
    input  logic              class_a_act,
    input  logic              reti,
    input  logic [ADDR_W-1:0] reti_ip,
    input  logic              trap_ack,
    output logic              trap_req,
    output logic [VEC_W-1:0]  trap_vec,
    output logic [ADDR_W-1:0] trap_ip
);
    typedef struct packed {
        logic              busy;
        logic              defer;
        logic              rel;
        logic              req;
        logic [VEC_W-1:0]  vec;
        logic [ADDR_W-1:0] ip;
        logic [ADDR_W-1:0] hold;
    } st_t;

    st_t st_d, st_q;

    logic [ADDR_W-1:0] cand [NFLAG];
    logic [ADDR_W-1:0] pick_ip;
    logic              fresh;
    logic              rel_now;
    logic [ADDR_W-1:0] rel_ip;

    // per-flag stacked address source
    for (genvar g = 0; g < NFLAG; g++) begin : g_cand
        localparam ipsrc_e SRC = ip_source(g);
        if (SRC == IPSRC_CUR) begin : g_cur
            assign cand[g] = cur_ip;
        end else if (SRC == IPSRC_BR) begin : g_br
            assign cand[g] = branch_target;
        end else begin : g_next
            assign cand[g] = next_ip;
        end
    end

    // lowest bit index has highest priority
    always_comb begin
        pick_ip = next_ip;
        for (int i = NFLAG - 1; i >= 0; i--) begin
            if (fault[i]) pick_ip = cand[i];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        st_d.vec = '0;
        fresh    = |fault;

        if (trap_ack) st_d.busy = 1'b0;

        if (fresh && class_a_act) st_d.defer = 1'b1;

        rel_now = st_q.rel || (reti && (st_q.defer || (fresh && class_a_act)));
        rel_ip  = st_q.rel ? st_q.hold : reti_ip;

        if (reti && !st_q.rel && (st_q.defer || (fresh && class_a_act))) begin
            st_d.defer = 1'b0;
            st_d.rel   = 1'b1;
            st_d.hold  = reti_ip;
        end

        if (!st_q.busy) begin
            if (rel_now) begin
                st_d.req  = 1'b1;
                st_d.vec  = TRAP_VEC;
                st_d.ip   = rel_ip;
                st_d.busy = 1'b1;
                st_d.rel  = 1'b0;
            end else if (fresh && !class_a_act) begin
                st_d.req  = 1'b1;
                st_d.vec  = TRAP_VEC;
                st_d.ip   = pick_ip;
                st_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trap_req = st_q.req;
    assign trap_vec = st_q.vec;
    assign trap_ip  = st_q.ip;
endmodule

// File: rtl/trapb_ctrl.sv
module trapb_ctrl
    import trapb_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter int               VEC_W    = 4,
    parameter logic [VEC_W-1:0] TRAP_VEC = 4'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic              insn_undef,
    input  logic              prot_viol,
    input  logic              data_req,
    input  logic              data_word,
    input  logic              data_addr_lsb,
    input  logic              branch_take,
    input  logic [ADDR_W-1:0] branch_target,
    input  logic              ext_req,
    input  logic              bus_cfg,
    input  logic [ADDR_W-1:0] cur_ip,
    input  logic [ADDR_W-1:0] next_ip,
    input  logic              reti,
    input  logic [ADDR_W-1:0] reti_ip,
    input  logic              class_a_act,
    input  logic              flag_wr,
    input  logic [4:0]        flag_wdata,
    input  logic              trap_ack,
    output logic [4:0]        flags,
    output logic              trap_req,
    output logic [VEC_W-1:0]  trap_vec,
    output logic [ADDR_W-1:0] trap_ip
);
    flag_t fault;

    trapb_detect u_detect (
        .insn_valid    (insn_valid),
        .insn_undef    (insn_undef),
        .prot_viol     (prot_viol),
        .data_req      (data_req),
        .data_word     (data_word),
        .data_addr_lsb (data_addr_lsb),
        .branch_take   (branch_take),
        .branch_lsb    (branch_target[0]),
        .ext_req       (ext_req),
        .bus_cfg       (bus_cfg),
        .fault         (fault)
    );

    trapb_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_set   (fault),
        .sw_wr    (flag_wr),
        .sw_wdata (flag_wdata),
        .flags    (flags)
    );

    trapb_issue #(
        .ADDR_W   (ADDR_W),
        .VEC_W    (VEC_W),
        .TRAP_VEC (TRAP_VEC)
    ) u_issue (
        .clk           (clk),
        .rst_n         (rst_n),
        .fault         (fault),
        .cur_ip        (cur_ip),
        .next_ip       (next_ip),
        .branch_target (branch_target),
        .class_a_act   (class_a_act),
        .reti          (reti),
        .reti_ip       (reti_ip),
        .trap_ack      (trap_ack),
        .trap_req      (trap_req),
        .trap_vec      (trap_vec),
        .trap_ip       (trap_ip)
    );
endmodule

// File: rtl/trapb_ctrl_chk.sv
module trapb_ctrl_chk #(
    parameter int               ADDR_W   = 16,
    parameter int               VEC_W    = 4,
    parameter logic [VEC_W-1:0] TRAP_VEC = 4'hA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_valid,
    input logic              insn_undef,
    input logic              prot_viol,
    input logic              data_req,
    input logic              data_word,
    input logic              data_addr_lsb,
    input logic              branch_take,
    input logic [ADDR_W-1:0] branch_target,
    input logic              ext_req,
    input logic              bus_cfg,
    input logic              flag_wr,
    input logic [4:0]        flag_wdata,
    input logic              trap_ack,
    input logic [4:0]        flags,
    input logic              trap_req,
    input logic [VEC_W-1:0]  trap_vec
);
    logic [4:0] cause;
    logic       pend_q;

    assign cause = {ext_req & ~bus_cfg,
                    data_req & data_word & data_addr_lsb,
                    branch_take & branch_target[0],
                    prot_viol,
                    insn_valid & insn_undef};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q | trap_req) & ~trap_ack;
    end

    for (genvar i = 0; i < 5; i++) begin : g_bit
        // R1
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cause[i] |=> flags[i]);
        // R5
        flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_wr && flag_wdata[i] && !cause[i]) |=> !flags[i]);
        // R10
        flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags[i] ##1 flags[i]) |-> $past(cause[i]));
    end

    // R7
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req);
    // R7
    vec_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_vec == TRAP_VEC));
    // R7
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> (trap_vec == '0));
    // R8
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !pend_q);
endmodule

bind trapb_ctrl trapb_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .VEC_W    (VEC_W),
    .TRAP_VEC (TRAP_VEC)
) u_chk (.*);

// File: tb/trapb_ctrl_test.sv
`timescale 1ns/1ps
module trapb_ctrl_test;
    localparam int ADDR_W = 16;
    localparam int VEC_W  = 4;
    localparam logic [VEC_W-1:0] VEC = 4'hA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic insn_valid = 0, insn_undef = 0, prot_viol = 0;
    logic data_req = 0, data_word = 0, data_addr_lsb = 0;
    logic branch_take = 0;
    logic [ADDR_W-1:0] branch_target = '0;
    logic ext_req = 0, bus_cfg = 1;
    logic [ADDR_W-1:0] cur_ip = '0, next_ip = '0, reti_ip = '0;
    logic reti = 0, class_a_act = 0, flag_wr = 0, trap_ack = 0;
    logic [4:0] flag_wdata = '0;
    logic [4:0] flags;
    logic trap_req;
    logic [VEC_W-1:0] trap_vec;
    logic [ADDR_W-1:0] trap_ip;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    trapb_ctrl #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .TRAP_VEC(VEC)) uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        insn_valid = 0; insn_undef = 0; prot_viol = 0;
        data_req = 0; data_word = 0; data_addr_lsb = 0;
        branch_take = 0; ext_req = 0; bus_cfg = 1;
        reti = 0; flag_wr = 0; flag_wdata = '0; trap_ack = 0;
    endtask

    task automatic drive_mask(input logic [4:0] m);
        insn_valid = 1; insn_undef = m[0];
        prot_viol = m[1];
        branch_take = m[2];
        data_req = m[3]; data_word = 1; data_addr_lsb = 1;
        ext_req = m[4]; bus_cfg = 0;
    endtask

    task automatic ack_and_clear();
        trap_ack = 1;
        @(negedge clk);
        trap_ack = 0; flag_wr = 1; flag_wdata = 5'h1f;
        @(negedge clk);
        flag_wr = 0; flag_wdata = '0;
    endtask

    function automatic logic [ADDR_W-1:0] exp_ip(input logic [4:0] m,
            input logic [ADDR_W-1:0] c, input logic [ADDR_W-1:0] n,
            input logic [ADDR_W-1:0] b);
        if (m[0] || m[1]) return c;
        if (m[2])         return b;
        return n;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11
        chk("R11 flags", flags, 0);
        chk("R11 trap_req", trap_req, 0);
        chk("R11 trap_vec", trap_vec, 0);

        // R1 R2 R3 R4 R7: sweep every fault combination
        for (int m = 0; m < 32; m++) begin
            logic [4:0] mm;
            mm = m[4:0];
            cur_ip = 16'h2000 + 16'(m * 4);
            next_ip = cur_ip + 16'd2;
            branch_target = 16'h3001 + 16'(m * 16);
            drive_mask(mm);
            @(negedge clk);
            idle_inputs();
            chk("R1 flags", flags, mm);
            chk("R7 trap_req", trap_req, (mm != 0));
            chk("R7 trap_vec", trap_vec, (mm != 0) ? VEC : 4'h0);
            if (mm != 0)
                chk("R4 trap_ip", trap_ip, exp_ip(mm, cur_ip, next_ip, branch_target));
            ack_and_clear();
            chk("R5 flags cleared", flags, 0);
            chk("R7 pulse ended", trap_req, 0);
        end

        // R10: lookalike conditions
        insn_valid = 0; insn_undef = 1;
        data_req = 1; data_word = 0; data_addr_lsb = 1;
        branch_take = 1; branch_target = 16'h4000;
        ext_req = 1; bus_cfg = 1;
        @(negedge clk);
        idle_inputs();
        branch_take = 1; branch_target = 16'h4001;
        data_req = 1; data_word = 1; data_addr_lsb = 0;
        branch_take = 0;
        @(negedge clk);
        idle_inputs();
        chk("R10 flags", flags, 0);
        chk("R10 trap_req", trap_req, 0);
        @(negedge clk);
        chk("R10 flags later", flags, 0);
        chk("R10 trap_req later", trap_req, 0);

        // R8: faults while a request is outstanding are dropped
        cur_ip = 16'h7000; next_ip = 16'h7002;
        drive_mask(5'b00001);
        @(negedge clk);
        idle_inputs();
        chk("R8 first req", trap_req, 1);
        drive_mask(5'b10000);
        @(negedge clk);
        idle_inputs();
        chk("R8 pulse ends", trap_req, 0);
        chk("R8 flags", flags, 5'b10001);
        trap_ack = 1;
        @(negedge clk);
        trap_ack = 0;
        seen = 0;
        for (int k = 0; k < 5; k++) begin
            if (trap_req) seen++;
            @(negedge clk);
        end
        chk("R8 dropped", seen, 0);
        flag_wr = 1; flag_wdata = 5'h1f;
        @(negedge clk);
        idle_inputs();

        // R9: deferral during Class A
        class_a_act = 1;
        cur_ip = 16'h6000;
        prot_viol = 1;
        @(negedge clk);
        prot_viol = 0;
        chk("R9 flag set", flags, 5'b00010);
        chk("R9 no req", trap_req, 0);
        seen = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (trap_req) seen++;
        end
        chk("R9 held off", seen, 0);
        reti = 1; reti_ip = 16'h5550;
        @(negedge clk);
        reti = 0; class_a_act = 0;
        chk("R9 req after reti", trap_req, 1);
        chk("R9 ip", trap_ip, 16'h5550);
        ack_and_clear();

        // R6: set wins over clear
        cur_ip = 16'h1234;
        flag_wr = 1; flag_wdata = 5'h1f;
        insn_valid = 1; insn_undef = 1;
        @(negedge clk);
        idle_inputs();
        chk("R6 set wins", flags, 5'b00001);
        chk("R2 ip", trap_ip, 16'h1234);
        ack_and_clear();

        // R5: partial clear
        cur_ip = 16'h0100; next_ip = 16'h0104;
        drive_mask(5'b01001);
        @(negedge clk);
        idle_inputs();
        trap_ack = 1;
        @(negedge clk);
        trap_ack = 0;
        chk("R5 both set", flags, 5'b01001);
        flag_wr = 1; flag_wdata = 5'b00001;
        @(negedge clk);
        idle_inputs();
        chk("R5 partial", flags, 5'b01000);

        // R3: single odd operand stacks next address
        flag_wr = 1; flag_wdata = 5'h1f;
        @(negedge clk);
        idle_inputs();
        next_ip = 16'h0abc;
        drive_mask(5'b01000);
        @(negedge clk);
        idle_inputs();
        chk("R3 next ip", trap_ip, 16'h0abc);
        ack_and_clear();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule